// File: doc/BRIEF.md
# Single-Core Exclusive Access Monitor

This block sits between one processor core and a small word-addressed memory and arbitrates load-linked / store-conditional style accesses. Each cycle the core may issue one operation: an ordinary load, an ordinary store, an exclusive load, an exclusive store or a clear of the reservation. Loads return the addressed word, and an exclusive store returns a status word that tells software whether it took effect.

The monitor holds a single reservation bit and no address, so the reservation covers the whole address space. Only the history of exclusive operations matters when an exclusive store is judged. An exclusive store succeeds exactly once after any exclusive load, at any address. Ordinary stores and loads leave the reservation alone. A lock-acquire loop built from an exclusive load, a compare and an exclusive store therefore works on a single core, with the granule as coarse as it can be.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is open, so an exclusive store issued first returns status 1 and leaves memory unchanged. This holds even when reset arrives while a reservation is held.
- R2: An exclusive load (op_code 3) returns the addressed word and moves the monitor to the exclusive state.
- R3: An exclusive store (op_code 4) in the exclusive state writes its data at its own address, even when that differs from the exclusive load's address. It returns status 0 and reopens the monitor.
- R4: An exclusive store in the open state writes nothing and returns status 1.
- R5: A second exclusive store after a successful one fails with status 1 and writes nothing.
- R6: A clear (op_code 5) reopens the monitor, so the next exclusive store fails.
- R7: An ordinary store (op_code 2) between an exclusive load and an exclusive store writes memory and does not clear the reservation.
- R8: An exclusive load issued while already exclusive keeps the monitor exclusive, and only one exclusive store then succeeds.
- R9: An ordinary load (op_code 1) returns the addressed word and does not change the monitor state.
- R10: Results appear one cycle after acceptance with rsp_valid high, only for op_codes 1, 3 and 4. The status word is DATA_W bits holding 0 (success) or 1 (failure). Otherwise rsp_valid and rsp_data are 0. op_code 0, and any operation with op_valid low, have no effect.
- R11: Only the low log2(DEPTH) address bits select the word, so addresses that differ by DEPTH refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 3 | 0 idle, 1 load, 2 store, 3 exclusive load, 4 exclusive store, 5 clear |
| op_addr | input | ADDR_W | Word address |
| op_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Result present, one cycle after the operation |
| rsp_data | output | DATA_W | Load data or exclusive-store status |

## Verification
The bench builds the block with DEPTH of 8, ADDR_W of 16 and DATA_W of 32. A depth of 8 puts address aliasing within reach using addresses 9 and 13, which test that only the low bits decode the word. The 32-bit data width lets the status word be checked for its full-width 0 and 1 values. Several distinct data patterns are written so that a store that should have been blocked shows up as a changed word on a later load.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_LOAD   = 3'd1,
    OP_STORE  = 3'd2,
    OP_XLOAD  = 3'd3,
    OP_XSTORE = 3'd4,
    OP_CLEAR  = 3'd5
  } op_e;

  // Operations that produce a response one cycle later
  function automatic logic has_response(op_e op);
    return (op == OP_LOAD) || (op == OP_XLOAD) || (op == OP_XSTORE);
  endfunction

  // Operations that return memory data
  function automatic logic returns_data(op_e op);
    return (op == OP_LOAD) || (op == OP_XLOAD);
  endfunction

endpackage

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
  import excl_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  op_e  op,
  output logic excl_q,
  output logic xs_pass,
  output logic xs_fail
);

  logic excl_d;

  assign xs_pass = acc && (op == OP_XSTORE) && excl_q;
  assign xs_fail = acc && (op == OP_XSTORE) && !excl_q;

  always_comb begin
    excl_d = excl_q;
    if (acc) begin
      unique case (op)
        OP_XLOAD:            excl_d = 1'b1;
        OP_XSTORE, OP_CLEAR: excl_d = 1'b0;
        default:             excl_d = excl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) excl_q <= 1'b0;
    else        excl_q <= excl_d;
  end

endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[idx] <= wdata;
    rd_q <= words[idx];
  end

endmodule

// File: rtl/excl_mon_rsp.sv
module excl_mon_rsp
  import excl_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  op_e               op,
  input  logic              xs_fail,
  input  logic [DATA_W-1:0] mem_rd,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic sel_data_q;
  logic fail_q;

  // Status word: zero on success, one on failure, zero-extended
  function automatic logic [DATA_W-1:0] status_word(logic failed);
    return {{(DATA_W-1){1'b0}}, failed};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      sel_data_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      rsp_valid  <= acc && has_response(op);
      sel_data_q <= acc && returns_data(op);
      fail_q     <= xs_fail;
    end
  end

  assign rsp_data = sel_data_q ? mem_rd
                  : (rsp_valid ? status_word(fail_q) : '0);

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  op_e              op;
  logic             excl_q;
  logic             xs_pass;
  logic             xs_fail;
  logic             mem_we;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] mem_rd;
  logic             unused_hi;

  function automatic logic [IDX_W-1:0] word_index(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  assign op        = op_e'(op_code);
  assign idx       = word_index(op_addr);
  assign unused_hi = ^op_addr[ADDR_W-1:IDX_W];
  assign mem_we    = (op_valid && (op == OP_STORE)) || xs_pass;

  excl_mon_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (op_valid),
    .op      (op),
    .excl_q  (excl_q),
    .xs_pass (xs_pass),
    .xs_fail (xs_fail)
  );

  excl_mon_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .idx   (idx),
    .wdata (op_wdata),
    .rd_q  (mem_rd)
  );

  excl_mon_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (op_valid),
    .op        (op),
    .xs_fail   (xs_fail),
    .mem_rd    (mem_rd),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
  import excl_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              excl_q,
  input logic              xs_pass,
  input logic              mem_we,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  p_open_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !excl_q);

  p_xload_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_XLOAD) |=> excl_q);

  p_xstore_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xs_pass |=> (rsp_valid && rsp_data == '0 && !excl_q));

  p_xstore_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_XSTORE && !excl_q) |-> !mem_we);

  p_xstore_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_XSTORE && !excl_q) |=> (rsp_valid && rsp_data == ONE));

  p_clear_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLEAR) |=> !excl_q);

  p_store_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STORE) |=> $stable(excl_q));

  p_load_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LOAD) |=> $stable(excl_q));

  p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rsp_valid && $stable(excl_q)));

endmodule

bind excl_mon_top excl_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .excl_q    (excl_q),
  .xs_pass   (xs_pass),
  .mem_we    (mem_we),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data)
);

// File: tb/sim_excl_mon_top.sv
module sim_excl_mon_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DP = 8;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        ev;
    logic [31:0] ed;
    logic [3:0]  req;
  } vec_t;

  // op codes: 0 idle, 1 load, 2 store, 3 xload, 4 xstore, 5 clear
  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 16'd1,  32'hAAAA, 1'b1, 32'd1,    4'd1},  // R1 first xstore fails
    '{3'd2, 16'd1,  32'h11,   1'b0, 32'd0,    4'd10}, // R10 store silent
    '{3'd1, 16'd1,  32'h0,    1'b1, 32'h11,   4'd4},  // R4 no write happened
    '{3'd2, 16'd2,  32'h22,   1'b0, 32'd0,    4'd10},
    '{3'd3, 16'd1,  32'h0,    1'b1, 32'h11,   4'd2},  // R2 xload data
    '{3'd4, 16'd2,  32'h6666, 1'b1, 32'd0,    4'd3},  // R3 other address ok
    '{3'd4, 16'd3,  32'h77,   1'b1, 32'd1,    4'd5},  // R5 second fails
    '{3'd1, 16'd2,  32'h0,    1'b1, 32'h6666, 4'd3},  // R3 written
    '{3'd2, 16'd3,  32'h33,   1'b0, 32'd0,    4'd10},
    '{3'd1, 16'd3,  32'h0,    1'b1, 32'h33,   4'd5},  // R5 no write
    '{3'd3, 16'd2,  32'h0,    1'b1, 32'h6666, 4'd2},
    '{3'd5, 16'd0,  32'h0,    1'b0, 32'd0,    4'd6},
    '{3'd4, 16'd2,  32'h99,   1'b1, 32'd1,    4'd6},  // R6 cleared
    '{3'd1, 16'd2,  32'h0,    1'b1, 32'h6666, 4'd6},
    '{3'd3, 16'd1,  32'h0,    1'b1, 32'h11,   4'd2},
    '{3'd2, 16'd1,  32'h55,   1'b0, 32'd0,    4'd7},  // R7 plain store
    '{3'd4, 16'd1,  32'h56,   1'b1, 32'd0,    4'd7},  // R7 still exclusive
    '{3'd1, 16'd1,  32'h0,    1'b1, 32'h56,   4'd7},
    '{3'd3, 16'd1,  32'h0,    1'b1, 32'h56,   4'd8},
    '{3'd3, 16'd3,  32'h0,    1'b1, 32'h33,   4'd8},  // R8 nested xload
    '{3'd4, 16'd3,  32'h44,   1'b1, 32'd0,    4'd8},
    '{3'd4, 16'd3,  32'h45,   1'b1, 32'd1,    4'd8},  // R8 only one pass
    '{3'd3, 16'd2,  32'h0,    1'b1, 32'h6666, 4'd9},
    '{3'd1, 16'd3,  32'h0,    1'b1, 32'h44,   4'd9},  // R9 load in exclusive
    '{3'd4, 16'd4,  32'h4,    1'b1, 32'd0,    4'd9},  // R9 state kept
    '{3'd1, 16'd9,  32'h0,    1'b1, 32'h56,   4'd11}, // R11 alias of 1
    '{3'd2, 16'd13, 32'h5D,   1'b0, 32'd0,    4'd11},
    '{3'd1, 16'd5,  32'h0,    1'b1, 32'h5D,   4'd11}, // R11 alias of 13
    '{3'd0, 16'd1,  32'hFF,   1'b0, 32'd0,    4'd10}  // R10 idle code
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  excl_mon_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input int req, input logic gv, input logic [DW-1:0] gd,
                       input logic ev, input logic [DW-1:0] ed);
    n_checks++;
    if (gv !== ev || gd !== ed) begin
      n_fail++;
      $display("FAIL R%0d: got valid=%0b data=%h, expected valid=%0b data=%h",
               req, gv, gd, ev, ed);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, output logic gv, output logic [DW-1:0] gd);
    @(negedge clk);
    op_valid = v; op_code = op; op_addr = a; op_wdata = wd;
    @(posedge clk);
    #2;
    gv = rsp_valid; gd = rsp_data;
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic gv;
    logic [DW-1:0] gd;
    repeat (3) @(posedge clk);
    #2;
    check(10, rsp_valid, rsp_data, 1'b0, '0); // R10 reset outputs quiet
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i].op, VEC[i].addr[AW-1:0], VEC[i].wd, gv, gd);
      check(int'(VEC[i].req), gv, gd, VEC[i].ev, VEC[i].ed);
    end

    // R10: op_valid low masks an exclusive store
    issue(1'b1, 3'd3, 16'd1, '0, gv, gd);
    issue(1'b0, 3'd4, 16'd1, 32'hBAD, gv, gd);
    check(10, gv, gd, 1'b0, '0);
    issue(1'b1, 3'd4, 16'd6, 32'h600, gv, gd);
    check(10, gv, gd, 1'b1, 32'd0);
    issue(1'b1, 3'd1, 16'd1, '0, gv, gd);
    check(10, gv, gd, 1'b1, 32'h56);

    // R1: reset while exclusive drops the reservation
    issue(1'b1, 3'd3, 16'd1, '0, gv, gd);
    go_idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    issue(1'b1, 3'd4, 16'd1, 32'hDEAD, gv, gd);
    check(1, gv, gd, 1'b1, 32'd1);
    issue(1'b1, 3'd1, 16'd1, '0, gv, gd);
    check(1, gv, gd, 1'b1, 32'h56);
    go_idle();
    @(posedge clk);
    #2;
    check(10, rsp_valid, rsp_data, 1'b0, '0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule